// File: doc/BRIEF.md
# GPIO Bank Register Block with Masked Data Writes

This block is the register file of one general-purpose I/O bank of up to 32 pins. Software reaches it over a simple single-cycle memory-mapped bus. It holds three sets of per-pin bits:

- the output data bits,
- the direction bits,
- the output-driver enable bits.

It also returns the already-synchronised pin input levels through a read-only register. The bank drives one output value and one output enable per pin toward the pad logic.

Output data is written through two half-bank registers, one for pins 0 to 15 and one for pins 16 to 31. Each write carries a 16-bit mask in its upper half. Software can therefore set or clear any subset of pins in one bus write, without a read-modify-write sequence that could race with another agent.

The bank index is a parameter, and the register offsets are derived from it, so one bank can sit beside its siblings in a shared address space. A second parameter gives the number of implemented pins. The unimplemented upper bits behave as constant zero.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset, all output data, direction and output-enable bits are 0, so `pin_out_o` and `pin_oe_o` are 0 and every register reads 0.
- R2: A write to the low data register (byte offset 8*BANK) updates output pin i (i from 0 to 15) to `wdata_i[i]` only when mask bit `wdata_i[16+i]` is 0. A set mask bit leaves that pin unchanged.
- R3: A write to the high data register (byte offset 8*BANK+4) applies the same rule to pins 16 to 31. Data bit i maps to pin 16+i, and mask bit 16+i guards it.
- R4: Reading either data register returns the current 16 output bits of that half in bits 15:0, with bits 31:16 read as 0.
- R5: The input register at byte offset 0x60+4*BANK returns the level of `pin_in_i`, one bit per pin, as sampled at the request edge. Writes to it have no effect.
- R6: The direction register at byte offset 0x204+0x40*BANK is read/write. A 1 marks the pin as an output.
- R7: The output-enable register at byte offset 0x208+0x40*BANK is read/write. A 1 turns on that pin's driver.
- R8: `pin_oe_o[i]` is 1 exactly when both direction bit i and output-enable bit i are 1. `pin_out_o[i]` always carries output data bit i.
- R9: Bits at positions NUM_PINS and above read as 0, ignore writes, and drive 0 on `pin_out_o` and `pin_oe_o`.
- R10: Read data appears on `rdata_o` in the cycle after a read request. Unmapped or non-word-aligned addresses read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request, one cycle per access |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| pin_in_i | input | 32 | Synchronised pin input levels |
| pin_out_o | output | 32 | Per-pin output value |
| pin_oe_o | output | 32 | Per-pin output driver enable |

## Verification
The bench builds the block with BANK = 1 and NUM_PINS = 22. With these values every offset differs from the bank-0 layout, so a write to a neighbouring bank's data register must be ignored. The pin count also leaves ten unimplemented bits, split across the high data half and the direction, enable and input registers. Outputs are compared every cycle against a behavioural model of the mask rule, and reads cover each register, a misaligned address and an unmapped address.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned HALF_W = DATA_W / 2;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_LO, SEL_HI, SEL_IN, SEL_DIR, SEL_OE
  } reg_sel_e;

  function automatic logic [DATA_W-1:0] impl_mask(int unsigned n);
    logic [DATA_W-1:0] m;
    for (int unsigned i = 0; i < DATA_W; i++) m[i] = (i < n);
    return m;
  endfunction
endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
  import gpio_bank_pkg::*;
#(
  parameter int unsigned BANK   = 0,
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  localparam logic [ADDR_W-1:0] OFS_LO  = ADDR_W'(8 * BANK);
  localparam logic [ADDR_W-1:0] OFS_HI  = ADDR_W'(8 * BANK + 4);
  localparam logic [ADDR_W-1:0] OFS_IN  = ADDR_W'(32'h60 + 4 * BANK);
  localparam logic [ADDR_W-1:0] OFS_DIR = ADDR_W'(32'h204 + 32'h40 * BANK);
  localparam logic [ADDR_W-1:0] OFS_OE  = ADDR_W'(32'h208 + 32'h40 * BANK);

  always_comb begin
    unique case (addr_i)
      OFS_LO:  sel_o = SEL_LO;
      OFS_HI:  sel_o = SEL_HI;
      OFS_IN:  sel_o = SEL_IN;
      OFS_DIR: sel_o = SEL_DIR;
      OFS_OE:  sel_o = SEL_OE;
      default: sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/gpio_bank_half.sv
// One 16-pin half of the output data, written under a per-bit mask.
module gpio_bank_half
  import gpio_bank_pkg::*;
#(
  parameter int unsigned BASE     = 0,
  parameter int unsigned NUM_PINS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [HALF_W-1:0] q_o
);
  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  for (genvar i = 0; i < HALF_W; i++) begin : g_bit
    if (BASE + i < NUM_PINS) begin : g_impl
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_o[i] <= 1'b0;
        else if (wr_i && !wdata_i[HALF_W+i]) q_o[i] <= wdata_i[i];
      end
    end else begin : g_tie
      assign q_o[i] = 1'b0;
    end
  end

  assert_hold_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(q_o));
  assert_full_mask_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[DATA_W-1:HALF_W] == '1) |=> $stable(q_o));
endmodule

// File: rtl/gpio_bank_ctl_reg.sv
module gpio_bank_ctl_reg
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  localparam logic [DATA_W-1:0] IMPL = impl_mask(NUM_PINS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else if (wr_i) q_o <= wdata_i & IMPL;
  end

  assert_ctl_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(q_o));
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned BANK     = 0,
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [31:0]       pin_in_i,
  output logic [31:0]       pin_out_o,
  output logic [31:0]       pin_oe_o
);
  localparam logic [DATA_W-1:0] IMPL = impl_mask(NUM_PINS);

  reg_sel_e          sel;
  logic              wr_lo, wr_hi, wr_dir, wr_oe;
  logic [HALF_W-1:0] lo_q, hi_q;
  logic [DATA_W-1:0] dir_q, oe_q, rd_mux;

  gpio_bank_decode #(.BANK(BANK), .ADDR_W(ADDR_W)) u_decode (
    .addr_i(addr_i), .sel_o(sel)
  );

  assign wr_lo  = req_i && we_i && sel == SEL_LO;
  assign wr_hi  = req_i && we_i && sel == SEL_HI;
  assign wr_dir = req_i && we_i && sel == SEL_DIR;
  assign wr_oe  = req_i && we_i && sel == SEL_OE;

  gpio_bank_half #(.BASE(0), .NUM_PINS(NUM_PINS)) u_half_lo (
    .clk_i, .rst_ni, .wr_i(wr_lo), .wdata_i, .q_o(lo_q)
  );
  gpio_bank_half #(.BASE(HALF_W), .NUM_PINS(NUM_PINS)) u_half_hi (
    .clk_i, .rst_ni, .wr_i(wr_hi), .wdata_i, .q_o(hi_q)
  );
  gpio_bank_ctl_reg #(.NUM_PINS(NUM_PINS)) u_dir (
    .clk_i, .rst_ni, .wr_i(wr_dir), .wdata_i, .q_o(dir_q)
  );
  gpio_bank_ctl_reg #(.NUM_PINS(NUM_PINS)) u_oe (
    .clk_i, .rst_ni, .wr_i(wr_oe), .wdata_i, .q_o(oe_q)
  );

  assign pin_out_o = {hi_q, lo_q};
  assign pin_oe_o  = dir_q & oe_q;

  always_comb begin
    unique case (sel)
      SEL_LO:  rd_mux = {{HALF_W{1'b0}}, lo_q};
      SEL_HI:  rd_mux = {{HALF_W{1'b0}}, hi_q};
      SEL_IN:  rd_mux = pin_in_i & IMPL;
      SEL_DIR: rd_mux = dir_q;
      SEL_OE:  rd_mux = oe_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (req_i && !we_i) rdata_o <= rd_mux;
  end

  assert_half_upper_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && (sel == SEL_LO || sel == SEL_HI)) |=> rdata_o[31:16] == '0);
  assert_ignored_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && (sel == SEL_NONE || sel == SEL_IN))
      |=> ($stable(pin_out_o) && $stable(pin_oe_o)));
  assert_oe_needs_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> $stable(pin_oe_o));
  assert_unimpl_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_out_o | pin_oe_o | dir_q | oe_q) & ~IMPL) == '0);
endmodule

// File: tb/gpio_bank_regs_tb.sv
module gpio_bank_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BANK = 1;
  localparam int NP = 22;
  localparam int AW = 12;
  localparam logic [31:0] IMPL = 32'h003F_FFFF;
  localparam logic [AW-1:0] A_LO = 12'h008, A_HI = 12'h00C, A_IN = 12'h064,
                            A_DIR = 12'h244, A_OE = 12'h248;

  logic clk = 0, rst_n = 0, req = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, pin_in = '0;
  logic [31:0] rdata, pin_out, pin_oe;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m_out = '0, m_dir = '0, m_oe = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank_regs #(.BANK(BANK), .NUM_PINS(NP), .ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_in_i(pin_in),
    .pin_out_o(pin_out), .pin_oe_o(pin_oe)
  );

  task automatic check(string req_tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
    end
  endtask

  // every-cycle comparison of pin outputs against the model
  always @(negedge clk) if (rst_n && !done) begin
    check("R2/R3/R9 pin_out", pin_out, m_out);
    check("R8 pin_oe", pin_oe, m_dir & m_oe);
  end

  task automatic model_write(logic [AW-1:0] a, logic [31:0] d);
    int base;
    base = -1;
    if (a == A_LO) base = 0;
    if (a == A_HI) base = 16;
    if (base >= 0) begin
      for (int i = 0; i < 16; i++)
        if (base + i < NP && !d[16+i]) m_out[base+i] = d[i];
    end
    if (a == A_DIR) m_dir = d & IMPL;
    if (a == A_OE) m_oe = d & IMPL;
  endtask

  function automatic logic [31:0] model_read(logic [AW-1:0] a);
    if (a == A_LO) return {16'h0, m_out[15:0]};
    if (a == A_HI) return {16'h0, m_out[31:16]};
    if (a == A_IN) return pin_in & IMPL;
    if (a == A_DIR) return m_dir;
    if (a == A_OE) return m_oe;
    return 32'h0;
  endfunction

  task automatic bus_wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk);
    #1 model_write(a, d);
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic bus_rd(string req_tag, logic [AW-1:0] a);
    logic [31:0] exp;
    @(negedge clk);
    req = 1; we = 0; addr = a;
    exp = model_read(a);
    @(posedge clk);
    @(negedge clk);
    req = 0;
    check(req_tag, rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 pin_out reset", pin_out, 32'h0);
    check("R1 pin_oe reset", pin_oe, 32'h0);
    bus_rd("R1 lo reset", A_LO);
    bus_rd("R1 hi reset", A_HI);
    bus_rd("R1 dir reset", A_DIR);
    bus_rd("R1 oe reset", A_OE);

    bus_wr(A_LO, 32'h0000_A5C3);
    bus_rd("R4 lo read", A_LO);
    check("R2 lo value", pin_out[15:0], 16'hA5C3);
    bus_wr(A_LO, 32'hFF00_0011);
    check("R2 partial mask", pin_out[15:0], 16'hA511);
    bus_wr(A_LO, 32'hFFFF_0000);
    check("R2 full mask", pin_out[15:0], 16'hA511);

    bus_wr(A_HI, 32'h0000_FFFF);
    bus_rd("R4 R9 hi read", A_HI);
    check("R3 R9 hi value", pin_out, 32'h003F_A511);
    bus_wr(A_HI, 32'hFFFE_0000);
    check("R3 single pin clear", pin_out, 32'h003E_A511);

    bus_wr(A_DIR, 32'hFFFF_FFFF);
    bus_rd("R6 R9 dir read", A_DIR);
    check("R8 oe off while enable 0", pin_oe, 32'h0);
    bus_wr(A_OE, 32'h0000_00F0);
    bus_rd("R7 oe read", A_OE);
    check("R8 oe both set", pin_oe, 32'h0000_00F0);
    bus_wr(A_DIR, 32'h0000_0030);
    check("R8 oe dir gated", pin_oe, 32'h0000_0030);

    pin_in = 32'hDEAD_BEEF;
    bus_rd("R5 R9 input read", A_IN);
    bus_wr(A_IN, 32'hFFFF_FFFF);
    check("R5 input write ignored", pin_out, 32'h003E_A511);
    pin_in = 32'h0012_3456;
    bus_rd("R5 input follows pins", A_IN);

    bus_wr(12'h000, 32'h0000_0000);
    check("R10 other bank write ignored", pin_out, 32'h003E_A511);
    bus_wr(12'h009, 32'h0000_0000);
    check("R10 misaligned write ignored", pin_out, 32'h003E_A511);
    bus_rd("R10 misaligned read", 12'h009);
    bus_rd("R10 unmapped read", 12'h100);
    bus_rd("R4 lo final", A_LO);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule